// File: doc/BRIEF.md
# Vectored interrupt flag controller

This block collects service requests from eight devices and turns them into one vectored interrupt for a small CPU. A device raises its request by pulsing its set line, which sets a flag flip-flop. Software can read all eight flags in parallel through the sense output, so the controller also supports polled operation. Each flag belongs to one of two classes, selected per device by `class_defer`. Immediate flags are taken at any instruction boundary, signalled by `insn_end`. Deferred flags are taken only when the CPU executes the designated output instruction, signalled by `defer_check`.

When at least one flag is eligible at a strobe, the controller picks the lowest-numbered one. It raises `irq_req` and presents a one-byte restart opcode on `vec_opcode`, which the CPU executes in place of a fetched instruction. It also presents the matching low-memory entry address on `vec_addr`. Device n gets opcode 8·n+5 (octal 0n5) and address 8·n (octal 00n0), so each device has an eight-word service slot. The request and opcode hold until the CPU pulses `cpu_ack`. That pulse clears the serviced device's flag and returns the controller to idle. Saving the return address on the CPU stack is not part of this block.

The sequencer has two states. ST_IDLE means no request is outstanding. ST_HOLD means a request is presented and waiting for acknowledge. The transition IDLE→HOLD ("grant") fires in a cycle where a strobe finds an eligible flag. The transition HOLD→IDLE ("release") fires when `cpu_ack` is high. In every other case the state stays where it is.

Top module: `vicf_top`

## Requirements
- R1: `sense_flags[n]` shows flag n. A high `dev_set[n]` in a cycle makes `sense_flags[n]` read 1 from the next cycle on, until it is acknowledged.
- R2: While `irq_req` is high for device n, `vec_opcode` equals {2'b00, n[2:0], 3'b101}, i.e. octal 0n5 (8·n+5). While `irq_req` is low, `vec_opcode` is 8'h00.
- R3: While `irq_req` is high for device n, `vec_addr` equals 8·n (octal 00n0). While `irq_req` is low, `vec_addr` is 0.
- R4: When `class_defer[n]`=0 marks flag n immediate, a set flag n present in a cycle with `insn_end`=1, while idle, raises `irq_req` for n from the next cycle.
- R5: When `class_defer[n]`=1 marks flag n deferred, `insn_end` alone never grants flag n. A set flag n present in a cycle with `defer_check`=1, while idle, is granted from the next cycle.
- R6: When several flags are eligible in the same grant cycle, the lowest-numbered one is granted.
- R7: Once raised, `irq_req`, `vec_opcode` and `vec_addr` stay unchanged until a cycle with `cpu_ack`=1. Strobes and set pulses meanwhile cause no new grant.
- R8: `cpu_ack`=1 while `irq_req` is high clears only the granted device's flag and drops `irq_req` in the next cycle.
- R9: A `dev_set[n]` pulse in the same cycle as the acknowledge for device n leaves flag n set.
- R10: `cpu_ack`=1 while `irq_req` is low changes no flag.
- R11: After reset all flags read 0, `irq_req` is low and `vec_opcode` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_set | input | 8 | Per-device set pulses for the flags |
| class_defer | input | 8 | Per-device class: 1 deferred, 0 immediate |
| insn_end | input | 1 | End-of-instruction strobe |
| defer_check | input | 1 | Strobe for the deferred-check output instruction |
| cpu_ack | input | 1 | Interrupt acknowledge from the CPU |
| irq_req | output | 1 | Interrupt request to the CPU |
| vec_opcode | output | 8 | Restart opcode to be executed |
| vec_addr | output | 14 | Entry address of the granted device's slot |
| sense_flags | output | 8 | All device flags, for polling |

## Verification
Directed runs walk each device through grant and acknowledge, which separates the eight opcode and address codes from one another. Mixed-class patterns present deferred flags to `insn_end` alone and then to `defer_check`, which tells the class gating apart from plain priority. Multi-flag patterns show whether the lowest index wins. Colliding set and acknowledge pulses, and acknowledges while idle, show whether a clear can leak onto the wrong flag or the wrong state. A long random phase then mixes strobes, set pulses, class masks and acknowledges, and compares every output each cycle against a bench model.

// File: rtl/vicf_pkg.sv
package vicf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } vicf_state_e;

    // Restart opcode layout: high two bits, three-bit slot number, low three bits
    localparam logic [1:0] RST_OPC_HIGH = 2'b00;
    localparam logic [2:0] RST_OPC_LOW  = 3'b101;
    localparam int         RST_SLOT_W   = 3;

endpackage

// File: rtl/vicf_flag_bank.sv
module vicf_flag_bank #(
    parameter int N_DEV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] set_vec,
    input  logic [N_DEV-1:0] clr_vec,
    output logic [N_DEV-1:0] flags
);

    for (genvar g = 0; g < N_DEV; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (set_vec[g]) begin
                // a set pulse outweighs a simultaneous clear
                flags[g] <= 1'b1;
            end else if (clr_vec[g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vicf_lowest_pick.sv
module vicf_lowest_pick #(
    parameter int N_DEV = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_DEV-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vicf_seq.sv
module vicf_seq
    import vicf_pkg::*;
#(
    parameter int N_DEV = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_found,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             cpu_ack,
    output logic             busy,
    output logic [IDX_W-1:0] held_idx,
    output logic [N_DEV-1:0] clr_vec
);

    vicf_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_found) begin          // grant
                    state_d = ST_HOLD;
                    idx_d   = pick_idx;
                end
            end
            ST_HOLD: begin
                if (cpu_ack) begin             // release
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        held_idx = idx_q;
        clr_vec  = '0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_HOLD: begin
                busy = 1'b1;
                if (cpu_ack) begin
                    clr_vec[idx_q] = 1'b1;
                end
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/vicf_top.sv
module vicf_top
    import vicf_pkg::*;
#(
    parameter int N_DEV      = 8,
    parameter int ADDR_W     = 14,
    parameter int SLOT_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DEV-1:0]  dev_set,
    input  logic [N_DEV-1:0]  class_defer,
    input  logic              insn_end,
    input  logic              defer_check,
    input  logic              cpu_ack,
    output logic              irq_req,
    output logic [7:0]        vec_opcode,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [N_DEV-1:0]  sense_flags
);

    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;

    logic [N_DEV-1:0] flags;
    logic [N_DEV-1:0] clr_vec;
    logic [N_DEV-1:0] class_open;
    logic [N_DEV-1:0] eligible;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic             busy;
    logic [IDX_W-1:0] held_idx;
    logic [RST_SLOT_W-1:0] slot;

    vicf_flag_bank #(.N_DEV(N_DEV)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (dev_set),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    // which classes the current strobes admit
    always_comb begin
        class_open = '0;
        if (insn_end)    class_open = class_open | ~class_defer;
        if (defer_check) class_open = class_open |  class_defer;
        eligible = flags & class_open;
    end

    vicf_lowest_pick #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_pick (
        .req   (eligible),
        .found (pick_found),
        .idx   (pick_idx)
    );

    vicf_seq #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_found (pick_found),
        .pick_idx   (pick_idx),
        .cpu_ack    (cpu_ack),
        .busy       (busy),
        .held_idx   (held_idx),
        .clr_vec    (clr_vec)
    );

    assign slot = RST_SLOT_W'(held_idx);

    always_comb begin
        if (busy) begin
            vec_opcode = {RST_OPC_HIGH, slot, RST_OPC_LOW};
            vec_addr   = ADDR_W'(held_idx) << SLOT_SHIFT;
        end else begin
            vec_opcode = 8'h00;
            vec_addr   = '0;
        end
    end

    assign irq_req     = busy;
    assign sense_flags = flags;

endmodule

// File: rtl/vicf_chk.sv
module vicf_chk #(
    parameter int N_DEV  = 8,
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_DEV-1:0]  dev_set,
    input logic              cpu_ack,
    input logic              irq_req,
    input logic [7:0]        vec_opcode,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [N_DEV-1:0]  sense_flags
);

    a_r1_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_set) |=> ((sense_flags & $past(dev_set)) == $past(dev_set)));

    a_r2_opcode_form: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (vec_opcode[2:0] == 3'b101 && vec_opcode[7:6] == 2'b00));

    a_r3_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (vec_addr == (ADDR_W'(vec_opcode[5:3]) << 3)));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !cpu_ack) |=> (irq_req && $stable(vec_opcode) && $stable(vec_addr)));

    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cpu_ack) |=> !irq_req);

    a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && cpu_ack && dev_set == '0) |=> (sense_flags == $past(sense_flags)));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (vec_opcode == 8'h00 && vec_addr == '0));

endmodule

bind vicf_top vicf_chk #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_set     (dev_set),
    .cpu_ack     (cpu_ack),
    .irq_req     (irq_req),
    .vec_opcode  (vec_opcode),
    .vec_addr    (vec_addr),
    .sense_flags (sense_flags)
);

// File: tb/vicf_top_tb.sv
module vicf_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dev_set = '0;
    logic [7:0]  class_defer = '0;
    logic        insn_end = 1'b0;
    logic        defer_check = 1'b0;
    logic        cpu_ack = 1'b0;
    logic        irq_req;
    logic [7:0]  vec_opcode;
    logic [13:0] vec_addr;
    logic [7:0]  sense_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_flags = '0;
    logic       m_busy = 1'b0;
    int         m_idx = 0;

    always #5 clk = ~clk;

    vicf_top u_dut (
        .clk(clk), .rst_n(rst_n), .dev_set(dev_set), .class_defer(class_defer),
        .insn_end(insn_end), .defer_check(defer_check), .cpu_ack(cpu_ack),
        .irq_req(irq_req), .vec_opcode(vec_opcode), .vec_addr(vec_addr),
        .sense_flags(sense_flags)
    );

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_opc();
        return m_busy ? 8'(8 * m_idx + 5) : 8'h00;
    endfunction

    function automatic logic [13:0] exp_addr();
        return m_busy ? 14'(8 * m_idx) : 14'd0;
    endfunction

    task automatic model_edge();
        logic [7:0] elig;
        logic [7:0] clr;
        clr = '0;
        if (m_busy && cpu_ack) clr = 8'(1) << m_idx;
        if (m_busy) begin
            if (cpu_ack) m_busy = 1'b0;
        end else begin
            elig = m_flags & ((insn_end ? ~class_defer : 8'h00) |
                              (defer_check ? class_defer : 8'h00));
            if (elig != 0) begin
                m_busy = 1'b1;
                m_idx  = lowest(elig);
            end
        end
        m_flags = (m_flags & ~clr) | dev_set;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        chk("R1", {ctx, " sense_flags"}, int'(sense_flags), int'(m_flags));
        chk("R4", {ctx, " irq_req"},     int'(irq_req),     int'(m_busy));
        chk("R2", {ctx, " vec_opcode"},  int'(vec_opcode),  int'(exp_opc()));
        chk("R3", {ctx, " vec_addr"},    int'(vec_addr),    int'(exp_addr()));
    endtask

    // called at a negedge: drive, take the edge, compare at next negedge
    task automatic step(input logic [7:0] s, input logic [7:0] c, input logic ie,
                        input logic dc, input logic ak, input string ctx);
        dev_set = s; class_defer = c; insn_end = ie; defer_check = dc; cpu_ack = ak;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        dev_set = '0; insn_end = 1'b0; defer_check = 1'b0; cpu_ack = 1'b0;
        check_all(ctx);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int unsigned r;
        seed = 32'h5EED1234;
        r = $urandom(seed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11 reset");

        step(8'h08, 8'h00, 0, 0, 0, "R1 set dev3");
        step(8'h00, 8'h00, 1, 0, 0, "R4 grant dev3");
        chk("R2", "opcode 035", int'(vec_opcode), 8'o035);
        step(8'h02, 8'h00, 1, 1, 0, "R7 strobes while held");
        chk("R7", "still dev3", int'(vec_opcode), 8'o035);
        step(8'h00, 8'h00, 0, 0, 1, "R8 ack dev3");
        chk("R8", "flags after ack", int'(sense_flags), 8'h02);
        step(8'h00, 8'h00, 1, 0, 0, "R4 grant dev1");
        step(8'h00, 8'h00, 0, 0, 1, "R8 ack dev1");

        for (int n = 0; n < 8; n++) begin
            step(8'(1) << n, 8'h00, 0, 0, 0, "R1 set each");
            step(8'h00, 8'h00, 1, 0, 0, "R2 each device");
            chk("R3", "slot address", int'(vec_addr), 8 * n);
            step(8'h00, 8'h00, 0, 0, 1, "R8 each ack");
        end

        step(8'h20, 8'hFF, 0, 0, 0, "R5 set deferred dev5");
        step(8'h00, 8'hFF, 1, 0, 0, "R5 insn_end alone");
        chk("R5", "deferred not taken", int'(irq_req), 0);
        step(8'h00, 8'hFF, 0, 1, 0, "R5 defer_check");
        chk("R5", "deferred opcode 055", int'(vec_opcode), 8'o055);
        step(8'h00, 8'hFF, 0, 0, 1, "R8 ack dev5");

        step(8'h12, 8'h02, 0, 0, 0, "R6 mixed classes");
        step(8'h00, 8'h02, 1, 0, 0, "R6 immediate over lower deferred");
        chk("R6", "dev4 chosen", int'(vec_opcode), 8'o045);
        step(8'h00, 8'h02, 0, 0, 1, "R8 ack dev4");
        step(8'h00, 8'h02, 0, 1, 0, "R5 deferred dev1");
        step(8'h00, 8'h02, 0, 0, 1, "R8 ack dev1");

        step(8'hA4, 8'h00, 0, 0, 0, "R6 set three");
        step(8'h00, 8'h00, 1, 0, 0, "R6 lowest wins");
        chk("R6", "dev2 chosen", int'(vec_opcode), 8'o025);
        step(8'h04, 8'h00, 0, 0, 1, "R9 set with ack");
        chk("R9", "dev2 kept", int'(sense_flags), 8'hA4);
        step(8'h00, 8'h00, 0, 0, 1, "R10 ack while idle");
        chk("R10", "flags kept", int'(sense_flags), 8'hA4);
        step(8'h00, 8'h00, 1, 0, 0, "R6 dev2 again");
        step(8'h00, 8'h00, 0, 0, 1, "R8 ack");
        step(8'h00, 8'h00, 1, 0, 0, "R6 dev5");
        chk("R6", "dev5 chosen", int'(vec_opcode), 8'o055);
        step(8'h00, 8'h00, 0, 0, 1, "R8 ack");

        for (int k = 0; k < 4000; k++) begin
            logic [7:0] s;
            logic [7:0] c;
            s = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            c = 8'($urandom);
            step(s, c, 1'($urandom % 3 == 0), 1'($urandom % 5 == 0),
                 1'($urandom % 3 == 0), "R7 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule